// File: doc/BRIEF.md
# Output Fault Filter and Retry Controller

This block holds the protection state of a bank of low-side output switches, sixteen by default. Digitised comparator flags arrive per output: load open while off, drain voltage high while on, and die too hot. A single supply-overvoltage flag is shared by all outputs. The block also receives the commanded on/off bits, the per-output pulldown enable and short-protect select bits, two global recovery policy bits, and single-cycle strobes for the select line's rising and falling edges. From these it produces the gate enables actually applied, the shutdown mask, latched fault flags, an any-fault bit and an overvoltage bit, together with a frozen snapshot of the flags for the serial status word.

Open-load and short faults count as real only after a filter window. The window is measured in microsecond ticks and restarts at every select rising edge, so that switching transients after a command never reach the flags. Thermal and overvoltage recoveries each follow their own programmed policy: come back on, or stay latched off until software turns the output off.

Top module: `fault_retry_ctrl`

## Requirements
- R1: After reset all fault flags, the shutdown mask, the any-fault bit, the overvoltage bit and the snapshot are 0, and each gate enable equals its command bit.
- R2: An output's fault flag is set by the open-load comparator only while the output is commanded off (command bit 0) and its pulldown enable bit is 1, and only after the comparator has stayed at 1 for FILT_TICKS ticks (default 300 ticks of TICK_CYCLES clocks each).
- R3: Every select rising strobe restarts the filter window, so a comparator held at 1 is flagged no earlier than FILT_TICKS ticks after the last strobe.
- R4: With its short-protect select bit at 0, a commanded-on output whose drain-high comparator stays at 1 for the filter window is shut off and flagged. With the select bit at 1, the drain-high comparator has no effect on it.
- R5: An output latched off by a fault stays off after the fault clears, and it is released only by its command bit being 0 for at least one clock, or by reset.
- R6: An over-temperature comparator at 1 shuts off that output alone one clock later and sets its flag.
- R7: When the over-temperature comparator returns to 0, the output comes back on if the thermal retry bit is 1, and stays latched off (per R5) if it is 0.
- R8: The overvoltage flag must stay at 1 for OV_TICKS ticks (default 50) before all outputs are shut off and the overvoltage bit is set. A shorter pulse has no effect.
- R9: When overvoltage clears, outputs return to their commanded state if the resume bit is 1. If it is 0, every output that was commanded on stays latched off (per R5).
- R10: Fault flags and the overvoltage bit stay at 1 after the condition clears, and are cleared by the select rising strobe.
- R11: The any-fault bit is 1 whenever any output fault flag or the overvoltage bit is 1.
- R12: The snapshot follows the live flags with one clock of lag. From the select falling strobe until the next rising strobe it holds the values captured one clock before the falling strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_rise_i | input | 1 | One-cycle strobe on select rising edge |
| cs_fall_i | input | 1 | One-cycle strobe on select falling edge |
| cmd_on_i | input | N_OUT | Commanded on/off per output |
| ol_en_i | input | N_OUT | Open-load pulldown enable per output |
| thermal_only_i | input | N_OUT | 1: thermal protection only, 0: drain-voltage shutdown as well |
| retry_thermal_i | input | 1 | 1: retry after cooling, 0: latch off |
| resume_ov_i | input | 1 | 1: resume after overvoltage, 0: latch off |
| openload_cmp_i | input | N_OUT | Open-load comparator per output |
| vds_high_i | input | N_OUT | Drain-voltage-high comparator per output |
| overtemp_i | input | N_OUT | Over-temperature comparator per output |
| overvolt_i | input | 1 | Supply overvoltage comparator |
| gate_en_o | output | N_OUT | Effective gate drive |
| shut_mask_o | output | N_OUT | Outputs currently forced off |
| fault_o | output | N_OUT | Live latched fault flags |
| any_fault_o | output | 1 | OR of all flags and overvoltage |
| ov_fault_o | output | 1 | Latched overvoltage shutdown |
| snap_fault_o | output | N_OUT | Snapshot of fault flags |
| snap_any_o | output | 1 | Snapshot of any-fault |
| snap_ov_o | output | 1 | Snapshot of overvoltage |

## Verification
The bench probes both sides of each filter boundary. A comparator sampled at expiry of the current window would still flag before the window ends, and one that ignored a mid-window select strobe would flag too early after it. It drives the recovery policies both ways and checks the lock after a drain-voltage trip. A design that let the lock lapse when the comparator cleared, or released it on anything other than a zero command bit, would turn the output back on. It checks that a snapshot does not move while a frame is open; a design without the freeze would show faults that arrived mid-frame.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef struct packed {
    logic ol_hit;     // open-load qualified this cycle
    logic sc_hit;     // drain-high qualified this cycle
    logic cool_lock;  // cooling edge that must latch off
  } chan_evt_t;

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  // saturating step used by every tick-based window
  function automatic int unsigned sat_step(input int unsigned cnt,
                                           input int unsigned lim,
                                           input logic adv);
    if (adv && cnt < lim) return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/frc_tick.sv
module frc_tick #(
  parameter int unsigned TICK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = frc_pkg::bits_for(TICK_CYCLES - 1);
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/frc_chan.sv
module frc_chan
  import frc_pkg::*;
#(
  parameter int unsigned FILT_TICKS = 300
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      cs_rise,
  input  logic      cmd_on,
  input  logic      ol_en,
  input  logic      thermal_only,
  input  logic      retry_thermal,
  input  logic      ol_cmp,
  input  logic      vds_high,
  input  logic      overtemp,
  input  logic      ov_block,
  input  logic      ov_lock_req,
  output logic      shut,
  output logic      fault,
  output chan_evt_t evt
);
  localparam int unsigned CW = bits_for(FILT_TICKS);
  localparam logic [CW-1:0] LIM = CW'(FILT_TICKS);

  logic [CW-1:0] win_q;
  logic lat_off_q, hot_q, fault_q;
  logic ol_cond, sc_cond, cond, at_lim;

  assign shut    = lat_off_q | hot_q | ov_block;
  // open-load and drain-high are mutually exclusive in command state,
  // so one window counter serves both
  assign ol_cond = ~cmd_on & ol_en & ol_cmp;
  assign sc_cond = cmd_on & ~thermal_only & vds_high & ~shut;
  assign cond    = ol_cond | sc_cond;
  assign at_lim  = (win_q == LIM);

  assign evt.ol_hit    = ol_cond & at_lim & ~cs_rise;
  assign evt.sc_hit    = sc_cond & at_lim & ~cs_rise;
  assign evt.cool_lock = hot_q & ~overtemp & ~retry_thermal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               win_q <= '0;
    else if (cs_rise | ~cond) win_q <= '0;
    else win_q <= CW'(sat_step(int'(win_q), FILT_TICKS, tick));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q     <= 1'b0;
      lat_off_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      hot_q     <= overtemp;
      lat_off_q <= cmd_on & (lat_off_q | evt.sc_hit | evt.cool_lock | ov_lock_req);
      fault_q   <= (fault_q & ~cs_rise) | evt.ol_hit | evt.sc_hit | hot_q;
    end
  end

  assign fault = fault_q;

  // R6
  ot_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> shut);
  // R4
  sc_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sc_hit |=> (shut && fault_q));
  // R5
  lat_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> !lat_off_q);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !cs_rise) |=> fault_q);
endmodule

// File: rtl/frc_ovmon.sv
module frc_ovmon
  import frc_pkg::*;
#(
  parameter int unsigned OV_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cs_rise,
  input  logic overvolt,
  input  logic resume_ov,
  output logic ov_active,
  output logic ov_flag,
  output logic ov_lock_req
);
  localparam int unsigned CW = bits_for(OV_TICKS);
  localparam logic [CW-1:0] LIM = CW'(OV_TICKS);

  logic [CW-1:0] qual_q;
  logic active_q, flag_q, ov_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         qual_q <= '0;
    else if (!overvolt) qual_q <= '0;
    else qual_q <= CW'(sat_step(int'(qual_q), OV_TICKS, tick));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      active_q <= overvolt & (active_q | (qual_q == LIM));
      flag_q   <= (flag_q & ~cs_rise) | active_q;
    end
  end

  assign ov_drop     = active_q & ~overvolt;
  assign ov_lock_req = ov_drop & ~resume_ov;
  assign ov_active   = active_q;
  assign ov_flag     = flag_q;

  // R8
  ov_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> flag_q);
  // R8
  ov_need_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overvolt |=> !active_q);
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
  import frc_pkg::*;
#(
  parameter int unsigned N_OUT       = 16,
  parameter int unsigned TICK_CYCLES = 4,
  parameter int unsigned FILT_TICKS  = 300,
  parameter int unsigned OV_TICKS    = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic [N_OUT-1:0] cmd_on_i,
  input  logic [N_OUT-1:0] ol_en_i,
  input  logic [N_OUT-1:0] thermal_only_i,
  input  logic             retry_thermal_i,
  input  logic             resume_ov_i,
  input  logic [N_OUT-1:0] openload_cmp_i,
  input  logic [N_OUT-1:0] vds_high_i,
  input  logic [N_OUT-1:0] overtemp_i,
  input  logic             overvolt_i,
  output logic [N_OUT-1:0] gate_en_o,
  output logic [N_OUT-1:0] shut_mask_o,
  output logic [N_OUT-1:0] fault_o,
  output logic             any_fault_o,
  output logic             ov_fault_o,
  output logic [N_OUT-1:0] snap_fault_o,
  output logic             snap_any_o,
  output logic             snap_ov_o
);
  logic tick, ov_active, ov_flag, ov_lock_req;
  logic [N_OUT-1:0] shut_w, fault_w;
  chan_evt_t [N_OUT-1:0] evt_w;

  frc_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  frc_ovmon #(.OV_TICKS(OV_TICKS)) ovmon_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs_rise(cs_rise_i),
    .overvolt(overvolt_i), .resume_ov(resume_ov_i),
    .ov_active(ov_active), .ov_flag(ov_flag), .ov_lock_req(ov_lock_req));

  for (genvar g = 0; g < N_OUT; g++) begin : g_chan
    frc_chan #(.FILT_TICKS(FILT_TICKS)) chan_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cs_rise(cs_rise_i),
      .cmd_on(cmd_on_i[g]), .ol_en(ol_en_i[g]),
      .thermal_only(thermal_only_i[g]), .retry_thermal(retry_thermal_i),
      .ol_cmp(openload_cmp_i[g]), .vds_high(vds_high_i[g]),
      .overtemp(overtemp_i[g]), .ov_block(ov_active),
      .ov_lock_req(ov_lock_req),
      .shut(shut_w[g]), .fault(fault_w[g]), .evt(evt_w[g]));
  end

  logic live_any;
  assign live_any = (|fault_w) | ov_flag;

  // snapshot for the serial status word, frozen across a frame
  logic             frame_q;
  logic [N_OUT-1:0] snap_fault_q;
  logic             snap_any_q, snap_ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q      <= 1'b0;
      snap_fault_q <= '0;
      snap_any_q   <= 1'b0;
      snap_ov_q    <= 1'b0;
    end else begin
      if (cs_rise_i)      frame_q <= 1'b0;
      else if (cs_fall_i) frame_q <= 1'b1;
      if (!(frame_q | cs_fall_i)) begin
        snap_fault_q <= fault_w;
        snap_any_q   <= live_any;
        snap_ov_q    <= ov_flag;
      end
    end
  end

  assign shut_mask_o  = shut_w;
  assign gate_en_o    = cmd_on_i & ~shut_w;
  assign fault_o      = fault_w;
  assign any_fault_o  = live_any;
  assign ov_fault_o   = ov_flag;
  assign snap_fault_o = snap_fault_q;
  assign snap_any_o   = snap_any_q;
  assign snap_ov_o    = snap_ov_q;

  // R8
  ov_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_active |-> (&shut_mask_o));
  // R12
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_q && !cs_rise_i) |=> $stable(snap_fault_q));
endmodule

// File: tb/fault_retry_ctrl_tb_top.sv
module fault_retry_ctrl_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_rise = 1'b0, cs_fall = 1'b0;
  logic [N-1:0] cmd_on = '0, ol_en = '0, th_only = '0;
  logic retry = 1'b0, resume = 1'b0;
  logic [N-1:0] ol_cmp = '0, vds = '0, ot = '0;
  logic ov = 1'b0;
  logic [N-1:0] gate_en, shut_mask, fault, snap_fault;
  logic any_fault, ov_fault, snap_any, snap_ov;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fault_retry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_rise_i(cs_rise), .cs_fall_i(cs_fall),
    .cmd_on_i(cmd_on), .ol_en_i(ol_en), .thermal_only_i(th_only),
    .retry_thermal_i(retry), .resume_ov_i(resume),
    .openload_cmp_i(ol_cmp), .vds_high_i(vds), .overtemp_i(ot),
    .overvolt_i(ov), .gate_en_o(gate_en), .shut_mask_o(shut_mask),
    .fault_o(fault), .any_fault_o(any_fault), .ov_fault_o(ov_fault),
    .snap_fault_o(snap_fault), .snap_any_o(snap_any), .snap_ov_o(snap_ov));

  // {cmd, en, cmp, expected flag} for open-load gating
  localparam logic [3:0] OL_VEC [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0111,
    4'b1000, 4'b1010, 4'b1100, 4'b1110 };

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise();
    cs_rise = 1'b1; @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic fall();
    cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cmd_on = 16'h00FF;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(gate_en == 16'h00FF, "R1 gate", 32'(gate_en), 32'h00FF);
    chk(fault == 0 && shut_mask == 0 && !any_fault && !ov_fault, "R1 flags",
        {fault, shut_mask}, 0);
    chk(snap_fault == 0 && !snap_any && !snap_ov, "R1 snap", 32'(snap_fault), 0);

    // R2 table walk on output 3
    for (int k = 0; k < 8; k++) begin
      cmd_on = '0; ol_en = '0; ol_cmp = '0;
      rise(); cyc(2);
      cmd_on[3] = OL_VEC[k][3]; ol_en[3] = OL_VEC[k][2]; ol_cmp[3] = OL_VEC[k][1];
      rise(); cyc(1300);
      chk(fault[3] == OL_VEC[k][0], "R2 vector", 32'(fault[3]), 32'(OL_VEC[k][0]));
    end
    cmd_on = '0; ol_en = '0; ol_cmp = '0; rise(); cyc(2);

    // R2 window boundary
    ol_en[3] = 1'b1; ol_cmp[3] = 1'b1;
    rise(); cyc(1150);
    chk(fault[3] == 1'b0, "R2 early", 32'(fault[3]), 0);
    cyc(150);
    chk(fault[3] == 1'b1, "R2 late", 32'(fault[3]), 1);
    ol_cmp = '0; rise(); cyc(2);

    // R3 restart by select strobe
    ol_cmp[3] = 1'b1;
    rise(); cyc(800);
    rise(); cyc(800);
    chk(fault[3] == 1'b0, "R3 restarted", 32'(fault[3]), 0);
    cyc(500);
    chk(fault[3] == 1'b1, "R3 after window", 32'(fault[3]), 1);
    // R10 latch then clear
    ol_cmp = '0; cyc(10);
    chk(fault[3] == 1'b1 && any_fault, "R10 held", 32'(fault[3]), 1);
    rise(); cyc(2);
    chk(fault[3] == 1'b0 && !any_fault, "R10 cleared", 32'(fault[3]), 0);
    ol_en = '0;

    // R4 drain-voltage shutdown on output 5
    cmd_on = 16'h0020; vds[5] = 1'b1;
    rise(); cyc(1150);
    chk(gate_en[5] == 1'b1, "R4 before window", 32'(gate_en), 32'h0020);
    cyc(150);
    chk(gate_en[5] == 1'b0 && fault[5] && shut_mask[5], "R4 tripped",
        32'(gate_en), 0);
    vds = '0; cyc(20);
    chk(gate_en[5] == 1'b0, "R5 stays off", 32'(gate_en), 0);
    cmd_on = '0; cyc(2); cmd_on = 16'h0020; cyc(2);
    chk(gate_en[5] == 1'b1, "R5 released", 32'(gate_en), 32'h0020);
    rise(); cyc(2);
    chk(fault[5] == 1'b0, "R10 short cleared", 32'(fault), 0);

    // R4 thermal-only select ignores drain voltage
    th_only[5] = 1'b1; vds[5] = 1'b1;
    rise(); cyc(1400);
    chk(gate_en[5] == 1'b1 && fault[5] == 1'b0, "R4 thermal only",
        {gate_en, fault}, {16'h0020, 16'h0000});
    vds = '0; th_only = '0;

    // R6 / R7 thermal
    cmd_on = 16'hFFFF; retry = 1'b1;
    ot[9] = 1'b1; cyc(2);
    chk(gate_en == 16'hFDFF, "R6 only that output", 32'(gate_en), 32'hFDFF);
    chk(fault == 16'h0200 && any_fault, "R11 any from output", 32'(fault), 32'h0200);
    ot = '0; cyc(2);
    chk(gate_en == 16'hFFFF, "R7 retry", 32'(gate_en), 32'hFFFF);
    retry = 1'b0;
    ot[9] = 1'b1; cyc(3); ot = '0; cyc(3);
    chk(gate_en[9] == 1'b0, "R7 latch", 32'(gate_en), 32'hFDFF);
    cmd_on[9] = 1'b0; cyc(2); cmd_on[9] = 1'b1; cyc(2);
    chk(gate_en == 16'hFFFF, "R7 released", 32'(gate_en), 32'hFFFF);
    rise(); cyc(2);
    chk(!any_fault, "R11 any clear", 32'(any_fault), 0);

    // R8 overvoltage qualification
    resume = 1'b1;
    ov = 1'b1; cyc(150); ov = 1'b0; cyc(3);
    chk(!ov_fault && gate_en == 16'hFFFF, "R8 short pulse", 32'(gate_en), 32'hFFFF);
    ov = 1'b1; cyc(180);
    chk(!ov_fault, "R8 not yet", 32'(ov_fault), 0);
    cyc(40);
    chk(ov_fault && any_fault && gate_en == 0, "R8 shutdown", 32'(gate_en), 0);
    ov = 1'b0; cyc(2);
    chk(gate_en == 16'hFFFF, "R9 resume", 32'(gate_en), 32'hFFFF);
    chk(ov_fault, "R10 ov held", 32'(ov_fault), 1);
    rise(); cyc(2);
    chk(!ov_fault && !any_fault, "R10 ov cleared", 32'(ov_fault), 0);

    // R9 latch-off policy
    resume = 1'b0;
    ov = 1'b1; cyc(220); ov = 1'b0; cyc(3);
    chk(gate_en == 0, "R9 latched", 32'(gate_en), 0);
    cmd_on = 16'hFF0F; cyc(2); cmd_on = 16'hFFFF; cyc(2);
    chk(gate_en == 16'h00F0, "R9 partial release", 32'(gate_en), 32'h00F0);
    cmd_on = '0; cyc(2); cmd_on = 16'hFFFF;
    rise(); cyc(2);

    // R12 snapshot freeze
    retry = 1'b1;
    ot[9] = 1'b1; cyc(2); ot = '0; cyc(2);
    fall(); cyc(2);
    chk(snap_fault == 16'h0200 && snap_any, "R12 captured", 32'(snap_fault), 32'h0200);
    ot[2] = 1'b1; cyc(3); ot = '0; cyc(2);
    chk(fault == 16'h0204, "R12 live moved", 32'(fault), 32'h0204);
    chk(snap_fault == 16'h0200, "R12 frozen", 32'(snap_fault), 32'h0200);
    rise(); cyc(3);
    chk(fault == 0 && snap_fault == 0 && !snap_any, "R12 tracks again",
        32'(snap_fault), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule